// File: doc/BRIEF.md
# Escape-Commanded ASCII Case Converter

This block sits in a character stream and rewrites the letter case of each 8-bit ASCII code that passes through it, one code per clock. The stream also carries its own control: an escape code (0x1B) followed by one of four command letters switches the block between forcing lower case, forcing upper case, leaving text as it is, and swapping the case of every letter. The chosen conversion stays in force for all following characters until another valid command is seen.

Each character takes exactly two clock cycles from input to output. The first register holds the incoming character. The second register holds the converted result. The escape code and its command letter are not removed from the stream. They come out like any other character, and their output values carry no meaning. Only bit 5 of an alphabetic code is ever altered, because an upper-case letter and its lower-case partner differ in that bit alone (lower = upper + 32).

Top module: `escase_conv`

## Requirements
- R1: While reset is high and after it is released, out_valid is 0 and out_char is 0x00. The starting conversion is keep: letters leave unaltered until a command is accepted.
- R2: Each accepted character (in_valid=1) appears on out_char with out_valid=1 exactly two clock cycles later. out_valid is 0 two cycles after a cycle with in_valid=0.
- R3: After 0x1B followed by 0x4C ('L'), every letter (A–Z, a–z) leaves with bit 5 set, which gives lower case.
- R4: After 0x1B followed by 0x55 ('U'), every letter leaves with bit 5 cleared, which gives upper case.
- R5: After 0x1B followed by 0x4E ('N'), every character leaves identical to its input.
- R6: After 0x1B followed by 0x43 ('C'), every letter leaves with bit 5 inverted.
- R7: Codes that are not letters (digits, punctuation, control codes, codes 0x80 and above) leave unchanged in every conversion.
- R8: Bits 7:6 and 4:0 of every output equal the same bits of the matching input.
- R9: A command is accepted only when the letter directly follows 0x1B among valid characters. Several things leave the conversion unchanged: 0x1B followed by any other code, for example 'x', 0x8C or a lower-case 'l'; a command letter with no 0x1B in front of it; and 0x1B presented with in_valid=0. A second 0x1B re-arms the escape, so 0x1B 0x1B 0x55 selects upper case.
- R10: The conversion holds for all later characters until a new command is accepted. Cycles with in_valid=0 between 0x1B and the letter are ignored, and so is the code present on in_char during those cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_char | input | 8 | Incoming ASCII code |
| in_valid | input | 1 | in_char holds a character this cycle |
| out_char | output | 8 | Converted ASCII code |
| out_valid | output | 1 | out_char holds a character this cycle |

## Verification
A wrong escape flag or conversion register is visible only on letters. It appears on out_char three cycles after the command letter is presented: one cycle to latch the conversion, then the two-cycle pipeline of the first following character. Sweeping all 256 codes under each conversion therefore exposes a wrong bit 5 on a letter, or any change to a non-letter, within one pass. Rejected escape sequences, and escape codes sent with in_valid low, are followed by letters so that an unwanted change of conversion reaches the output.

// File: rtl/escase_pkg.sv
package escase_pkg;

    localparam int CHAR_W   = 8;
    localparam int CASE_BIT = 5;

    typedef logic [CHAR_W-1:0] char_t;

    // Conversion encoding equals bits 1:0 of the command letter.
    typedef enum logic [1:0] {
        CASE_LOWER = 2'b00,
        CASE_UPPER = 2'b01,
        CASE_KEEP  = 2'b10,
        CASE_FLIP  = 2'b11
    } case_mode_e;

    typedef struct packed {
        logic  valid;
        char_t data;
    } beat_t;

    localparam char_t ESC_CODE  = 8'h1B;
    localparam char_t KEY_LOWER = 8'h4C;
    localparam char_t KEY_UPPER = 8'h55;
    localparam char_t KEY_KEEP  = 8'h4E;
    localparam char_t KEY_FLIP  = 8'h43;
    localparam char_t CASE_MASK = char_t'(1) << CASE_BIT;

    function automatic logic is_alpha(input char_t c);
        char_t folded;
        folded = c | CASE_MASK;
        return (folded >= 8'h61) && (folded <= 8'h7A);
    endfunction

    function automatic logic is_command(input char_t c);
        return (c == KEY_LOWER) || (c == KEY_UPPER) ||
               (c == KEY_KEEP)  || (c == KEY_FLIP);
    endfunction

    function automatic case_mode_e mode_of(input char_t c);
        return case_mode_e'(c[1:0]);
    endfunction

endpackage

// File: rtl/escase_cmd_decoder.sv
module escase_cmd_decoder
    import escase_pkg::*;
(
    input  char_t      key,
    output logic       hit,
    output case_mode_e sel
);
    always_comb begin
        hit = is_command(key);
        sel = mode_of(key);
    end
endmodule

// File: rtl/escase_ctrl.sv
module escase_ctrl
    import escase_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  beat_t      in_beat,
    output logic       esc_seen,
    output case_mode_e cur_mode
);
    logic       cmd_hit;
    case_mode_e cmd_sel;

    escase_cmd_decoder dec_i (
        .key (in_beat.data),
        .hit (cmd_hit),
        .sel (cmd_sel)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            esc_seen <= 1'b0;
            cur_mode <= CASE_KEEP;
        end else if (in_beat.valid) begin
            esc_seen <= (in_beat.data == ESC_CODE);
            if (esc_seen && cmd_hit) begin
                cur_mode <= cmd_sel;
            end
        end
    end
endmodule

// File: rtl/escase_bit_xform.sv
module escase_bit_xform
    import escase_pkg::*;
(
    input  beat_t      src,
    input  case_mode_e mode,
    output beat_t      dst
);
    logic new_bit;

    always_comb begin
        unique case (mode)
            CASE_LOWER: new_bit = 1'b1;
            CASE_UPPER: new_bit = 1'b0;
            CASE_KEEP:  new_bit = src.data[CASE_BIT];
            CASE_FLIP:  new_bit = ~src.data[CASE_BIT];
            default:    new_bit = src.data[CASE_BIT];
        endcase
        dst = src;
        if (is_alpha(src.data)) begin
            dst.data[CASE_BIT] = new_bit;
        end
    end
endmodule

// File: rtl/escase_beat_reg.sv
module escase_beat_reg
    import escase_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  beat_t d,
    output beat_t q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/escase_conv.sv
module escase_conv
    import escase_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] in_char,
    input  logic       in_valid,
    output logic [7:0] out_char,
    output logic       out_valid
);
    beat_t      in_beat;
    beat_t      s1_beat;
    beat_t      xf_beat;
    beat_t      s2_beat;
    logic       esc_seen;
    case_mode_e cur_mode;
    logic       s1_valid;
    char_t      s1_char;

    assign in_beat.valid = in_valid;
    assign in_beat.data  = in_char;

    escase_ctrl ctrl_i (
        .clk      (clk),
        .rst      (rst),
        .in_beat  (in_beat),
        .esc_seen (esc_seen),
        .cur_mode (cur_mode)
    );

    escase_beat_reg stage1_i (
        .clk (clk),
        .rst (rst),
        .d   (in_beat),
        .q   (s1_beat)
    );

    escase_bit_xform xform_i (
        .src  (s1_beat),
        .mode (cur_mode),
        .dst  (xf_beat)
    );

    escase_beat_reg stage2_i (
        .clk (clk),
        .rst (rst),
        .d   (xf_beat),
        .q   (s2_beat)
    );

    assign s1_valid  = s1_beat.valid;
    assign s1_char   = s1_beat.data;
    assign out_char  = s2_beat.data;
    assign out_valid = s2_beat.valid;
endmodule

// File: rtl/escase_conv_chk.sv
module escase_conv_chk
    import escase_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic [7:0] in_char,
    input logic       in_valid,
    input logic [7:0] out_char,
    input logic       out_valid,
    input logic       s1_valid,
    input logic [7:0] s1_char,
    input logic       esc_seen,
    input logic [1:0] cur_mode
);
    logic [7:0] d1_q, d2_q;
    logic       v1_q, v2_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            d1_q <= '0; d2_q <= '0; v1_q <= 1'b0; v2_q <= 1'b0;
        end else begin
            d1_q <= in_char; d2_q <= d1_q; v1_q <= in_valid; v2_q <= v1_q;
        end
    end

    p_latency_r2: assert property (@(posedge clk) disable iff (rst)
        out_valid == v2_q);

    p_other_bits_r8: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (((out_char ^ d2_q) & ~CASE_MASK) == 8'h00));

    p_nonalpha_r7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !is_alpha(d2_q)) |-> (out_char == d2_q));

    p_lower_r3: assert property (@(posedge clk) disable iff (rst)
        (s1_valid && is_alpha(s1_char) && cur_mode == 2'(CASE_LOWER)) |=> out_char[CASE_BIT]);

    p_upper_r4: assert property (@(posedge clk) disable iff (rst)
        (s1_valid && is_alpha(s1_char) && cur_mode == 2'(CASE_UPPER)) |=> !out_char[CASE_BIT]);

    p_keep_r5: assert property (@(posedge clk) disable iff (rst)
        (s1_valid && cur_mode == 2'(CASE_KEEP)) |=> (out_char == $past(s1_char)));

    p_flip_r6: assert property (@(posedge clk) disable iff (rst)
        (s1_valid && is_alpha(s1_char) && cur_mode == 2'(CASE_FLIP))
            |=> (out_char[CASE_BIT] != $past(s1_char[CASE_BIT])));

    p_arm_r9: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_char == ESC_CODE) |=> esc_seen);

    p_reject_r9: assert property (@(posedge clk) disable iff (rst)
        (in_valid && esc_seen && !is_command(in_char)) |=> $stable(cur_mode));

    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !(in_valid && esc_seen) |=> $stable(cur_mode));
endmodule

bind escase_conv escase_conv_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .in_char   (in_char),
    .in_valid  (in_valid),
    .out_char  (out_char),
    .out_valid (out_valid),
    .s1_valid  (s1_valid),
    .s1_char   (s1_char),
    .esc_seen  (esc_seen),
    .cur_mode  (cur_mode)
);

// File: tb/escase_conv_tb.sv
`timescale 1ns/1ps
module escase_conv_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] in_char = 8'h00;
    logic       in_valid = 1'b0;
    logic [7:0] out_char;
    logic       out_valid;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;
    bit mon_on = 1'b0;
    int bmode = 2; // 0 lower, 1 upper, 2 keep, 3 flip

    logic [7:0] q_exp[$];
    bit         q_care[$];
    string      q_req[$];

    always #2 clk = ~clk;

    escase_conv dut_i (
        .clk(clk), .rst(rst), .in_char(in_char), .in_valid(in_valid),
        .out_char(out_char), .out_valid(out_valid)
    );

    function automatic logic [7:0] model(input logic [7:0] c, input int m);
        logic [7:0] f;
        f = c | 8'h20;
        if (!(f >= 8'h61 && f <= 8'h7A)) return c;
        case (m)
            0: return c | 8'h20;
            1: return c & 8'hDF;
            3: return c ^ 8'h20;
            default: return c;
        endcase
    endfunction

    function automatic string tag_for(input logic [7:0] c, input int m);
        logic [7:0] f;
        f = c | 8'h20;
        if (!(f >= 8'h61 && f <= 8'h7A)) return "R7";
        case (m)
            0: return "R3";
            1: return "R4";
            3: return "R6";
            default: return "R5";
        endcase
    endfunction

    task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one valid character at the current negedge, advance one cycle.
    task automatic drive(input logic [7:0] c, input bit care, input string req);
        in_char  = c;
        in_valid = 1'b1;
        q_exp.push_back(model(c, bmode));
        q_care.push_back(care);
        q_req.push_back(req);
        @(negedge clk);
    endtask

    task automatic idle(input logic [7:0] c, input int n);
        for (int i = 0; i < n; i++) begin
            in_char  = c;
            in_valid = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic command(input logic [7:0] key);
        drive(8'h1B, 1'b0, "R9");
        drive(key, 1'b0, "R9");
        case (key)
            8'h4C: bmode = 0;
            8'h55: bmode = 1;
            8'h4E: bmode = 2;
            8'h43: bmode = 3;
            default: ;
        endcase
    endtask

    task automatic sweep();
        for (int c = 0; c < 256; c++) begin
            drive(8'(c), 1'b1, tag_for(8'(c), bmode));
        end
    endtask

    task automatic letters(input string req);
        drive(8'h61, 1'b1, req);
        drive(8'h42, 1'b1, req);
        drive(8'h7A, 1'b1, req);
        drive(8'h51, 1'b1, req);
    endtask

    // Output monitor: compares each valid output against the model queue (R2, R8).
    always @(negedge clk) begin
        if (mon_on && out_valid) begin
            if (q_exp.size() == 0) begin
                check("R2", {1'b1, out_char}, {1'b0, out_char});
            end else begin
                logic [7:0] e;
                bit         cr;
                string      rq;
                e  = q_exp.pop_front();
                cr = q_care.pop_front();
                rq = q_req.pop_front();
                if (cr) check(rq, {1'b0, out_char}, {1'b0, e});
                else check("R8", {1'b0, out_char & 8'hDF}, {1'b0, e & 8'hDF});
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs held at zero during reset
        check("R1", {out_valid, out_char}, 9'h000);
        rst = 1'b0;
        @(negedge clk);
        check("R1", {out_valid, out_char}, 9'h000);
        mon_on = 1'b1;

        // R2: single character, exact two-cycle latency
        in_char = 8'h61; in_valid = 1'b1;
        q_exp.push_back(8'h61); q_care.push_back(1'b1); q_req.push_back("R1");
        @(negedge clk);
        idle(8'h00, 0);
        in_valid = 1'b0;
        check("R2", {8'h00, out_valid}, 9'h000);
        @(negedge clk);
        check("R2", {out_valid, out_char}, {1'b1, 8'h61});
        @(negedge clk);
        check("R2", {8'h00, out_valid}, 9'h000);

        // R1/R5/R7: default keep, then each conversion over all codes
        sweep();
        command(8'h4C); sweep();
        command(8'h55); sweep();
        command(8'h43); sweep();
        command(8'h4E); sweep();

        // R9: rejected escapes keep upper case selected
        command(8'h55);
        drive(8'h1B, 1'b0, "R9"); drive(8'h78, 1'b1, "R9"); letters("R9");
        drive(8'h1B, 1'b0, "R9"); drive(8'h8C, 1'b1, "R9"); letters("R9");
        drive(8'h1B, 1'b0, "R9"); drive(8'h6C, 1'b1, "R9"); letters("R9");
        drive(8'h4C, 1'b1, "R9"); letters("R9");
        // R9: escape with in_valid low is not an escape
        idle(8'h1B, 1); drive(8'h4C, 1'b1, "R9"); letters("R9");
        // R9: double escape re-arms
        drive(8'h1B, 1'b0, "R9"); command(8'h4C); letters("R9");

        // R10: bubbles (with a command code on the bus) between escape and letter
        drive(8'h1B, 1'b0, "R10");
        idle(8'h55, 3);
        drive(8'h43, 1'b0, "R10");
        bmode = 3;
        letters("R10");
        idle(8'h4C, 4);
        letters("R10");
        drive(8'h35, 1'b1, "R7");
        letters("R10");

        in_valid = 1'b0;
        repeat (4) @(negedge clk);
        check("R2", {23'd0, q_exp.size() == 0}, 24'd1 > 0 ? 9'h001 : 9'h000);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule